// File: doc/BRIEF.md
# SPI Slave Transfer Terminator

This block sits beside the receive datapath of an SPI slave and decides where each transfer begins and ends. It watches the slave-select pin coming from the external master and a one-cycle strobe that the shifter raises for every received bit. From these it produces three outputs. `xfer_active` marks the span of a transfer. `irq_flag` is a sticky interrupt that is raised when a transfer ends. `quota_ok` reports whether the transfer delivered exactly the configured number of words of the configured length.

Two termination styles are offered. In edge mode a transfer is framed only by select edges. The counted bits never end it, and a transfer whose select never returns to the inactive level never raises the interrupt. In level mode the transfer also ends on its own as soon as the configured quota of bits has been received. Releasing select early cuts the transfer short, and `quota_ok` then shows the shortfall. The select polarity is programmable. The select pin is asynchronous and passes through a synchronizer before any edge is detected. The block carries no data stream, so it has no valid/ready interface; every pin is plain control or status.

Top module: `spi_xfer_term`

## Requirements
- R1: Select is active when its synchronized value equals `cfg_act_high` (1 = active high, 0 = active low). A change on `ss_pin` that is present before rising edge k is reflected in `xfer_active` at rising edge k+2, after two synchronizer flops and one edge-detect register.
- R2: In edge mode (`cfg_level` = 0) a transfer starts on a select activation and ends only on the next select deactivation. At that same clock edge `xfer_active` falls and `irq_flag` rises.
- R3: In edge mode, no number of received bits ends a transfer. While select stays active `xfer_active` stays 1 and `irq_flag` is not set.
- R4: In level mode (`cfg_level` = 1), a select deactivation during a transfer ends it at once and sets `irq_flag`, however many bits have been counted.
- R5: In level mode, the bit strobe that brings the count to `cfg_bit_len` × `cfg_words` ends the transfer on that clock edge, sets `irq_flag` and sets `quota_ok` to 1. The later release of select raises no further interrupt.
- R6: At each transfer end `quota_ok` becomes 1 exactly when the counted bits equal `cfg_bit_len` × `cfg_words`, and 0 otherwise, including on overrun. It holds its value until the next end.
- R7: `irq_flag` stays set until `irq_clr` is 1 on a clock edge. If a transfer ends on the same edge as `irq_clr`, the set wins.
- R8: Bit and word counts restart from zero at every transfer start.
- R9: After reset `irq_flag`, `quota_ok` and `xfer_active` are 0, and the synchronizer holds the inactive select level, so a select that is already inactive causes no event.
- R10: A bit strobe is counted only while `xfer_active` is 1 and no select edge is detected in that cycle. Strobes outside a transfer change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ss_pin | input | 1 | Asynchronous slave-select from the external master |
| bit_stb | input | 1 | One-cycle pulse per received bit |
| cfg_bit_len | input | LEN_W | Bits per word, 1 to MAX_BITS |
| cfg_words | input | CNT_W | Words per transfer, 1 to MAX_WORDS |
| cfg_level | input | 1 | 0 = edge mode, 1 = level mode |
| cfg_act_high | input | 1 | Select polarity, 1 = active high |
| irq_clr | input | 1 | Write-one-to-clear for `irq_flag` |
| irq_flag | output | 1 | Sticky end-of-transfer interrupt |
| quota_ok | output | 1 | Last transfer received exactly the configured quota |
| xfer_active | output | 1 | Transfer in progress |

## Verification
Some rules are checked on every cycle. The interrupt rises only on the edge where `xfer_active` falls, and every fall of `xfer_active` leaves the interrupt set. The flag persists until a clear arrives and drops after a clear when no transfer is running. `quota_ok` never moves except at a transfer end. Other behaviour depends on timing and on the configuration, so only the bench scenarios show it: the two-flop synchronizer latency, the quota-driven early end in level mode against its absence in edge mode, the overrun and shortfall outcomes, counter restart, strobes ignored outside a transfer, and a clear that lands on the same edge as an end.

// File: rtl/spi_term_pkg.sv
package spi_term_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  typedef struct packed {
    logic start;
    logic stop;
  } sel_evt_t;
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync
  import spi_term_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ss_pin,
  input  logic     act_high,
  output sel_evt_t evt
);
  logic [STAGES-1:0] chain;
  logic              sel_act;
  logic              act_q;

  // Metastability chain, preloaded with the inactive level on reset.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= ~act_high;
      else if (g == 0) chain[g] <= ss_pin;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign sel_act = (chain[STAGES-1] == act_high);

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= sel_act;
  end

  assign evt.start = sel_act & ~act_q;
  assign evt.stop  = ~sel_act & act_q;
endmodule

// File: rtl/spi_bit_quota.sv
module spi_bit_quota #(
  parameter int LEN_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count,
  input  logic [LEN_W-1:0] cfg_bit_len,
  input  logic [CNT_W-1:0] cfg_words,
  output logic             at_quota,
  output logic             last_bit
);
  logic [LEN_W-1:0] bit_cnt;
  logic [CNT_W:0]   word_cnt;   // one spare bit so an overrun never aliases
  logic [LEN_W-1:0] len_m1;
  logic [CNT_W:0]   words_ext;
  logic [CNT_W:0]   word_inc;
  logic             word_last;

  assign len_m1    = cfg_bit_len - 1'b1;
  assign words_ext = {1'b0, cfg_words};
  assign word_inc  = word_cnt + 1'b1;
  assign word_last = (bit_cnt == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
    end else if (count) begin
      if (word_last) begin
        bit_cnt <= '0;
        if (word_cnt != '1) word_cnt <= word_inc;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign at_quota = (word_cnt == words_ext) && (bit_cnt == '0);
  assign last_bit = word_last && (word_inc == words_ext);
endmodule

// File: rtl/spi_xfer_term.sv
module spi_xfer_term
  import spi_term_pkg::*;
#(
  parameter int  MAX_BITS    = 32,
  parameter int  MAX_WORDS   = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int LEN_W       = $clog2(MAX_BITS + 1),
  localparam int CNT_W       = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ss_pin,
  input  logic             bit_stb,
  input  logic [LEN_W-1:0] cfg_bit_len,
  input  logic [CNT_W-1:0] cfg_words,
  input  logic             cfg_level,
  input  logic             cfg_act_high,
  input  logic             irq_clr,
  output logic             irq_flag,
  output logic             quota_ok,
  output logic             xfer_active
);
  sel_evt_t   evt;
  trig_mode_e mode;
  logic       count_en;
  logic       stop_end;
  logic       cnt_end;
  logic       end_evt;
  logic       at_quota;
  logic       last_bit;

  assign mode = trig_mode_e'(cfg_level);

  spi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ss_pin   (ss_pin),
    .act_high (cfg_act_high),
    .evt      (evt)
  );

  spi_bit_quota #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_quota (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (evt.start),
    .count       (count_en),
    .cfg_bit_len (cfg_bit_len),
    .cfg_words   (cfg_words),
    .at_quota    (at_quota),
    .last_bit    (last_bit)
  );

  always_comb begin
    count_en = xfer_active & bit_stb & ~evt.start & ~evt.stop;
    stop_end = xfer_active & evt.stop;
    cnt_end  = count_en & (mode == TRIG_LEVEL) & last_bit;
    end_evt  = stop_end | cnt_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_active <= 1'b0;
      irq_flag    <= 1'b0;
      quota_ok    <= 1'b0;
    end else begin
      if (evt.start)    xfer_active <= 1'b1;
      else if (end_evt) xfer_active <= 1'b0;

      if (end_evt)      irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;

      if (end_evt)      quota_ok <= cnt_end | at_quota;
    end
  end
endmodule

// File: rtl/spi_xfer_term_chk.sv
module spi_xfer_term_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_clr,
  input logic irq_flag,
  input logic quota_ok,
  input logic xfer_active
);
  p_irq_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active) |-> irq_flag);

  // R3: the flag never rises without a transfer ending
  p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $fell(xfer_active));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && irq_clr && !xfer_active) |=> !irq_flag);

  p_quota_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(xfer_active) |-> $stable(quota_ok));
endmodule

bind spi_xfer_term spi_xfer_term_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_clr     (irq_clr),
  .irq_flag    (irq_flag),
  .quota_ok    (quota_ok),
  .xfer_active (xfer_active)
);

// File: tb/test_spi_xfer_term.sv
module test_spi_xfer_term;
  localparam int LEN_W = 6;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ss_pin = 1'b1;
  logic             bit_stb = 1'b0;
  logic [LEN_W-1:0] cfg_bit_len = 6'd8;
  logic [CNT_W-1:0] cfg_words = 4'd2;
  logic             cfg_level = 1'b0;
  logic             cfg_act_high = 1'b0;
  logic             irq_clr = 1'b0;
  logic             irq_flag, quota_ok, xfer_active;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string phase = "R9";

  always #10 clk = ~clk;

  spi_xfer_term i_spi_xfer_term (
    .clk, .rst_n, .ss_pin, .bit_stb, .cfg_bit_len, .cfg_words,
    .cfg_level, .cfg_act_high, .irq_clr, .irq_flag, .quota_ok, .xfer_active
  );

  // Behavioural reference: pin delay line, total bit tally, sticky flags.
  logic m_s1, m_s2, m_prev;
  logic m_act, m_irq, m_quota;
  int   m_bits;
  always @(posedge clk) begin
    logic cur, st, sp, ev;
    int   target;
    target = int'(cfg_bit_len) * int'(cfg_words);
    if (!rst_n) begin
      m_s1 = !cfg_act_high; m_s2 = !cfg_act_high; m_prev = 0;
      m_act = 0; m_irq = 0; m_quota = 0; m_bits = 0;
    end else begin
      cur = (m_s2 == cfg_act_high);
      st = cur && !m_prev;
      sp = !cur && m_prev;
      ev = 0;
      if (st) begin
        m_act = 1; m_bits = 0;
      end else if (m_act && sp) begin
        ev = 1; m_act = 0; m_quota = (m_bits == target);
      end else if (m_act && bit_stb) begin
        m_bits++;
        if (cfg_level && m_bits == target) begin
          ev = 1; m_act = 0; m_quota = 1;
        end
      end
      if (ev) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      m_prev = cur; m_s2 = m_s1; m_s1 = ss_pin;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "model irq_flag", int'(irq_flag), int'(m_irq));
      chk(phase, "model quota_ok", int'(quota_ok), int'(m_quota));
      chk(phase, "model xfer_active", int'(xfer_active), int'(m_act));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(bit active);
    ss_pin = active ? cfg_act_high : ~cfg_act_high;
  endtask

  task automatic bits(int n);
    repeat (n) begin
      @(negedge clk);
      bit_stb = 1'b1;
    end
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    // R9: idle outputs after reset, inactive select causes no start
    chk("R9", "irq after reset", int'(irq_flag), 0);
    chk("R9", "quota after reset", int'(quota_ok), 0);
    chk("R9", "active after reset", int'(xfer_active), 0);

    // R1 latency, active low, edge mode
    phase = "R1";
    sel(1);
    wait_n(2);
    chk("R1", "active before sync settles", int'(xfer_active), 0);
    wait_n(1);
    chk("R1", "active two edges after capture", int'(xfer_active), 1);

    // R2: exact quota in edge mode, ended only by release
    phase = "R2";
    bits(16);
    wait_n(3);
    chk("R2", "still active after quota", int'(xfer_active), 1);
    chk("R2", "no irq before release", int'(irq_flag), 0);
    sel(0);
    wait_n(3);
    chk("R2", "ended on release", int'(xfer_active), 0);
    chk("R2", "irq on release", int'(irq_flag), 1);
    chk("R6", "quota met", int'(quota_ok), 1);
    phase = "R7";
    pulse_clr();
    chk("R7", "irq cleared", int'(irq_flag), 0);

    // R3: overrun without inactive edge, then set wins over clear
    phase = "R3";
    sel(1);
    wait_n(4);
    bits(20);
    wait_n(10);
    chk("R3", "no end without release", int'(xfer_active), 1);
    chk("R3", "no irq without release", int'(irq_flag), 0);
    phase = "R7";
    irq_clr = 1'b1;
    sel(0);
    wait_n(3);
    chk("R7", "set wins over clear", int'(irq_flag), 1);
    chk("R6", "overrun not ok", int'(quota_ok), 0);
    wait_n(1);
    chk("R7", "clear takes next edge", int'(irq_flag), 0);
    irq_clr = 1'b0;

    // Switch to active high, level mode, under reset
    rst_n = 1'b0;
    cfg_act_high = 1'b1;
    cfg_level = 1'b1;
    ss_pin = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    chk("R9", "no event after polarity reset", int'(xfer_active), 0);

    // R4: early release in level mode
    phase = "R4";
    sel(1);
    wait_n(4);
    bits(5);
    wait_n(2);
    chk("R4", "active mid transfer", int'(xfer_active), 1);
    sel(0);
    wait_n(3);
    chk("R4", "early release ends", int'(xfer_active), 0);
    chk("R4", "early release irq", int'(irq_flag), 1);
    chk("R6", "short transfer not ok", int'(quota_ok), 0);
    pulse_clr();

    // R5 and R8: count end in level mode, counters restarted
    phase = "R8";
    sel(1);
    wait_n(4);
    bits(11);
    chk("R8", "counts restarted", int'(xfer_active), 1);
    phase = "R5";
    bits(5);
    chk("R5", "count end", int'(xfer_active), 0);
    chk("R5", "count end irq", int'(irq_flag), 1);
    chk("R5", "count end quota", int'(quota_ok), 1);
    pulse_clr();
    phase = "R10";
    bits(3);
    sel(0);
    wait_n(5);
    chk("R5", "no irq on later release", int'(irq_flag), 0);
    chk("R10", "idle strobes no effect", int'(quota_ok), 1);

    // R6/R10: edge mode, other geometry, strobes before start ignored
    phase = "R10";
    cfg_level = 1'b0;
    cfg_bit_len = 6'd5;
    cfg_words = 4'd3;
    bits(6);
    chk("R10", "idle strobes no start", int'(xfer_active), 0);
    sel(1);
    wait_n(4);
    bits(15);
    sel(0);
    wait_n(3);
    chk("R6", "5x3 quota met", int'(quota_ok), 1);
    chk("R2", "irq edge mode 5x3", int'(irq_flag), 1);
    pulse_clr();

    // R4/R6: level mode one word, shortfall by one bit
    phase = "R4";
    cfg_level = 1'b1;
    cfg_bit_len = 6'd4;
    cfg_words = 4'd1;
    sel(1);
    wait_n(4);
    bits(3);
    sel(0);
    wait_n(3);
    chk("R6", "shortfall not ok", int'(quota_ok), 0);
    chk("R4", "shortfall irq", int'(irq_flag), 1);
    wait_n(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule